// File: doc/BRIEF.md
# Vector lane address generator

This block forms one memory address per vector lane. It takes a vector of base addresses, a vector of offsets and a 32-bit operation word. The word is decoded into a lane layout and a scale amount. Each lane's result is its base plus its offset shifted left by 0 to 3 places, kept to the lane width. Every lane is computed, with no predication.

There are four layouts. Two are packed: all 32-bit lanes, or all 64-bit lanes, and each uses the full lane-width offset as an unsigned value. Two are unpacked: 64-bit lanes that use only the low 32 bits of each offset, either sign-extended or zero-extended. Words that do not match the fixed opcode bits raise a one-cycle undefined strobe and produce no result. The three register index fields of the word are passed through beside the result. The vector length is a parameter, a multiple of 64 bits.

Top module: `vec_addr_gen`

## Requirements
- R1: A word is legal only when bits [31:24] are 8'h04, bit 21 is 1 and bits [15:12] are 4'hA. An accepted word that is not legal gives `out_undef` high for exactly one cycle, one clock after it is accepted, and gives no `out_valid`.
- R2: A legal accepted word (`in_valid` high) gives `out_valid` high on the next cycle only. A synchronous active-high `rst` clears `out_valid` and `out_undef`.
- R3: When bit 23 is 1 and bit 22 is 0 (packed, 32-bit lanes), each 32-bit lane i gives base_i + offs_i * 2^s mod 2^32, with the offset taken as unsigned.
- R4: When bit 23 is 1 and bit 22 is 1 (packed, 64-bit lanes), each 64-bit lane gives base + offs * 2^s mod 2^64, with the full 64-bit offset taken as unsigned.
- R5: When bit 23 is 0 and bit 22 is 0 (unpacked signed), each 64-bit lane gives base + sext(offs[31:0]) * 2^s mod 2^64. Offset bits [63:32] have no effect.
- R6: When bit 23 is 0 and bit 22 is 1 (unpacked unsigned), each 64-bit lane gives base + zext(offs[31:0]) * 2^s mod 2^64. Offset bits [63:32] have no effect.
- R7: A carry out of one lane never reaches the next lane, in either lane width.
- R8: With the result, `out_dst` gives word bits [4:0], `out_base_idx` gives bits [9:5] and `out_offs_idx` gives bits [20:16].
- R9: The scale s is word bits [11:10], so the multiplier is 1, 2, 4 or 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and word are present this cycle |
| insn | input | 32 | Operation word |
| base_vec | input | VLEN | Base address vector |
| offs_vec | input | VLEN | Offset vector |
| out_valid | output | 1 | Result registered for a legal word |
| out_undef | output | 1 | Accepted word was not legal |
| out_result | output | VLEN | Per-lane address vector |
| out_dst | output | 5 | Destination register index |
| out_base_idx | output | 5 | Base register index |
| out_offs_idx | output | 5 | Offset register index |

## Verification
The assertions check on every cycle that the two strobes never rise together, that each strobe follows its accepted word by one cycle, that the index fields follow the word, and that the lowest lane matches the arithmetic in the packed 32-bit and unpacked unsigned layouts. The full lane arithmetic for every lane can only be shown by the bench's sweep. The sweep covers all four layouts, all four scale values, carry patterns at lane edges, sign-bit offsets and junk in the upper offset bits. Only the bench's scenarios show that every fixed opcode bit is decoded, each one flipped in turn.

// File: rtl/vag_pkg.sv
package vag_pkg;

  typedef enum logic [1:0] {
    MODE_P32 = 2'd0,
    MODE_P64 = 2'd1,
    MODE_SXT = 2'd2,
    MODE_UXT = 2'd3
  } vag_mode_e;

  typedef struct packed {
    logic      legal;
    vag_mode_e mode;
    logic [1:0] shamt;
    logic [4:0] rm;
    logic [4:0] rn;
    logic [4:0] rd;
  } vag_dec_t;

  localparam logic [7:0] OPC_TOP = 8'h04;
  localparam logic [3:0] OPC_MID = 4'hA;

endpackage

// File: rtl/vag_decode.sv
module vag_decode
  import vag_pkg::*;
(
  input  logic [31:0] insn,
  output vag_dec_t    dec
);

  always_comb begin
    dec.legal = (insn[31:24] == OPC_TOP) && insn[21] && (insn[15:12] == OPC_MID);
    case ({insn[23], insn[22]})
      2'b10:   dec.mode = MODE_P32;
      2'b11:   dec.mode = MODE_P64;
      2'b00:   dec.mode = MODE_SXT;
      default: dec.mode = MODE_UXT;
    endcase
    dec.shamt = insn[11:10];
    dec.rm    = insn[20:16];
    dec.rn    = insn[9:5];
    dec.rd    = insn[4:0];
  end

endmodule

// File: rtl/vag_lane64.sv
module vag_lane64
  import vag_pkg::*;
(
  input  logic [63:0] base,
  input  logic [63:0] offs,
  input  vag_mode_e   mode,
  input  logic [1:0]  shamt,
  output logic [63:0] res
);

  logic [63:0] ext_off;
  logic [63:0] wide_sum;
  logic [31:0] lo_sum;
  logic [31:0] hi_sum;

  always_comb begin
    case (mode)
      MODE_SXT: ext_off = {{32{offs[31]}}, offs[31:0]};
      MODE_UXT: ext_off = {32'h0, offs[31:0]};
      default:  ext_off = offs;
    endcase
    wide_sum = base + (ext_off << shamt);
    // two independent 32-bit adders: no carry crosses bit 31
    lo_sum   = base[31:0]  + (offs[31:0]  << shamt);
    hi_sum   = base[63:32] + (offs[63:32] << shamt);
    res      = (mode == MODE_P32) ? {hi_sum, lo_sum} : wide_sum;
  end

endmodule

// File: rtl/vec_addr_gen.sv
module vec_addr_gen
  import vag_pkg::*;
#(
  parameter int VLEN = 256
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [31:0]     insn,
  input  logic [VLEN-1:0] base_vec,
  input  logic [VLEN-1:0] offs_vec,
  output logic            out_valid,
  output logic            out_undef,
  output logic [VLEN-1:0] out_result,
  output logic [4:0]      out_dst,
  output logic [4:0]      out_base_idx,
  output logic [4:0]      out_offs_idx
);

  localparam int CHUNKS = VLEN / 64;

  vag_dec_t        dec;
  logic [VLEN-1:0] sum_vec;

  vag_decode dec_i (
    .insn (insn),
    .dec  (dec)
  );

  for (genvar c = 0; c < CHUNKS; c++) begin : g_chunk
    vag_lane64 lane_i (
      .base  (base_vec[c*64 +: 64]),
      .offs  (offs_vec[c*64 +: 64]),
      .mode  (dec.mode),
      .shamt (dec.shamt),
      .res   (sum_vec[c*64 +: 64])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_undef <= 1'b0;
    end else begin
      out_valid <= in_valid & dec.legal;
      out_undef <= in_valid & ~dec.legal;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && dec.legal) begin
      out_result   <= sum_vec;
      out_dst      <= dec.rd;
      out_base_idx <= dec.rn;
      out_offs_idx <= dec.rm;
    end
  end

endmodule

// File: rtl/vag_checker.sv
module vag_checker #(
  parameter int VLEN = 256
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [31:0]     insn,
  input logic [VLEN-1:0] base_vec,
  input logic [VLEN-1:0] offs_vec,
  input logic            out_valid,
  input logic            out_undef,
  input logic [VLEN-1:0] out_result,
  input logic [4:0]      out_dst,
  input logic [4:0]      out_base_idx,
  input logic [4:0]      out_offs_idx
);

  logic fmt_ok;
  assign fmt_ok = (insn[31:24] == 8'h04) && insn[21] && (insn[15:12] == 4'hA);

  assert_excl_strobes_R1: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && out_undef));

  assert_undef_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !fmt_ok) |=> (out_undef && !out_valid));

  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fmt_ok) |=> (out_valid && !out_undef));

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !out_undef));

  assert_index_pass_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fmt_ok) |=> (out_dst == $past(insn[4:0]) &&
                              out_base_idx == $past(insn[9:5]) &&
                              out_offs_idx == $past(insn[20:16])));

  assert_lane0_p32_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fmt_ok && insn[23:22] == 2'b10) |=>
      (out_result[31:0] == 32'($past(base_vec[31:0]) + ($past(offs_vec[31:0]) << $past(insn[11:10])))));

  assert_lane0_uxt_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fmt_ok && insn[23:22] == 2'b01) |=>
      (out_result[63:0] == 64'($past(base_vec[63:0]) + ({32'h0, $past(offs_vec[31:0])} << $past(insn[11:10])))));

endmodule

bind vec_addr_gen vag_checker #(.VLEN(VLEN)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .insn         (insn),
  .base_vec     (base_vec),
  .offs_vec     (offs_vec),
  .out_valid    (out_valid),
  .out_undef    (out_undef),
  .out_result   (out_result),
  .out_dst      (out_dst),
  .out_base_idx (out_base_idx),
  .out_offs_idx (out_offs_idx)
);

// File: tb/vec_addr_gen_tb.sv
`timescale 1ns/1ps
module vec_addr_gen_tb_top;

  localparam int VL = 128;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [31:0]   insn = 32'h0;
  logic [VL-1:0] base_vec = '0;
  logic [VL-1:0] offs_vec = '0;
  logic          out_valid;
  logic          out_undef;
  logic [VL-1:0] out_result;
  logic [4:0]    out_dst;
  logic [4:0]    out_base_idx;
  logic [4:0]    out_offs_idx;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  vec_addr_gen #(.VLEN(VL)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
    .base_vec(base_vec), .offs_vec(offs_vec),
    .out_valid(out_valid), .out_undef(out_undef), .out_result(out_result),
    .out_dst(out_dst), .out_base_idx(out_base_idx), .out_offs_idx(out_offs_idx)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [VL-1:0] act, input logic [VL-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic b23, input logic b22, input logic [1:0] sh,
                                     input logic [4:0] zm, input logic [4:0] zn, input logic [4:0] zd);
    return {8'h04, b23, b22, 1'b1, zm, 4'hA, sh, zn, zd};
  endfunction

  // arithmetic reference: mode 0=p32 1=p64 2=signed 3=unsigned
  function automatic logic [VL-1:0] model(input int md, input int sh,
                                          input logic [VL-1:0] b, input logic [VL-1:0] o);
    logic [VL-1:0] r;
    longint unsigned mult;
    mult = longint'(1) << sh;
    r = '0;
    if (md == 0) begin
      for (int i = 0; i < VL/32; i++) begin
        longint unsigned t;
        t = longint'(b[i*32 +: 32]) + longint'(o[i*32 +: 32]) * mult;
        r[i*32 +: 32] = t[31:0];
      end
    end else begin
      for (int i = 0; i < VL/64; i++) begin
        longint unsigned off;
        if (md == 1)      off = o[i*64 +: 64];
        else if (md == 2) off = longint'(int'(o[i*64 +: 32]));
        else              off = longint'(o[i*64 +: 32]);
        r[i*64 +: 64] = b[i*64 +: 64] + off * mult;
      end
    end
    return r;
  endfunction

  function automatic logic [VL-1:0] rnd_vec();
    logic [VL-1:0] v;
    for (int i = 0; i < VL/32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    string tags [4];
    tags[0] = "R3"; tags[1] = "R4"; tags[2] = "R5"; tags[3] = "R6";
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && out_undef == 1'b0, "R2", "reset strobes",
        {out_valid, out_undef}, '0);
    rst = 1'b0;
    @(negedge clk);

    for (int md = 0; md < 4; md++) begin
      for (int sh = 0; sh < 4; sh++) begin       // R9 sweep of every scale
        for (int p = 0; p < 6; p++) begin
          logic [VL-1:0] b, o, exp;
          logic [4:0] zm, zn, zd;
          string req;
          b = rnd_vec(); o = rnd_vec();
          req = $sformatf("%s/R9", tags[md]);
          if (p == 1) begin b = '1; o = {VL/32{32'h1}}; req = {req, "/R7"}; end
          if (p == 2) o = {VL/32{32'h8000_0000}};
          if (p == 3) begin o = {VL/32{32'hFFFF_FFFF}}; req = {req, "/R7"}; end
          zm = 5'($urandom); zn = 5'($urandom); zd = 5'($urandom);
          exp = model(md, sh, b, o);
          insn = mk(md < 2, (md == 1) || (md == 3), 2'(sh), zm, zn, zd);
          base_vec = b; offs_vec = o; in_valid = 1'b1;
          @(negedge clk);
          in_valid = 1'b0;
          chk(out_valid && !out_undef, "R2", "valid strobe", {out_valid, out_undef}, 2'b10);
          chk(out_result == exp, req, "lane result", out_result, exp);
          chk({out_offs_idx, out_base_idx, out_dst} == {zm, zn, zd}, "R8", "indices",
              {out_offs_idx, out_base_idx, out_dst}, {zm, zn, zd});
          @(negedge clk);
          chk(!out_valid, "R2", "single-cycle valid", out_valid, 0);
        end
      end
    end

    // R1: flip each fixed opcode bit in turn
    for (int k = 0; k < 32; k++) begin
      if ((k >= 24) || (k == 21) || (k >= 12 && k <= 15)) begin
        logic [31:0] w;
        w = mk(1'b1, 1'b0, 2'd1, 5'd3, 5'd4, 5'd5);
        w[k] = ~w[k];
        insn = w; base_vec = rnd_vec(); offs_vec = rnd_vec(); in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_undef && !out_valid, "R1", $sformatf("undef bit %0d", k),
            {out_valid, out_undef}, 2'b01);
        @(negedge clk);
        chk(!out_undef && !out_valid, "R1", "undef one cycle", {out_valid, out_undef}, 2'b00);
      end
    end

    // R2: reset while a legal word is offered
    insn = mk(1'b1, 1'b1, 2'd0, 5'd1, 5'd2, 5'd3); in_valid = 1'b1; rst = 1'b1;
    @(negedge clk);
    chk(!out_valid && !out_undef, "R2", "reset blocks strobe", {out_valid, out_undef}, 2'b00);
    in_valid = 1'b0; rst = 1'b0;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule